// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block chooses what drives each of two timing-generator paths: a primary path and a secondary path. For each path the choice is either one of `NUM_REFS` input references or a fallback operating state. The fallback states are freerun, pseudo-holdover and holdover. The secondary path has one more option: it can track the primary path's output. Software programs the block through a small write/read register port. One register sets the control mode, one manual selection word exists per path, and one pre-selection word holds two primary-path choices.

In pin mode, an external switch pin chooses which of the two pre-selected choices drives the primary path. The pin is first synchronized and then filtered against short pulses. The secondary path never looks at the pin. The synchronized pin level can be read back as a status bit.

Each path is a small state machine with five states: LOCK, FREE, PSEUDO, HOLD and TRACK. TRACK is reachable only on the secondary path. On every clock edge, a path moves from whatever state it is in to the state named by its requested selection code. The possible transitions are:
- any state to LOCK, with the reference index loaded from the code;
- any state to FREE, PSEUDO or HOLD;
- any state to TRACK, on the secondary path only.

A move that changes the state or the reference index raises a one-cycle change strobe.

Top module: `ref_sel_ctrl`

## Requirements

- R1: After reset, both paths report state FREE (code 1) with reference index 0. The mode register reads 0, both manual registers read 8, and the pre-selection register reads 0x10. Both change strobes are low.
- R2: In idle mode (mode value 0), both paths are held in FREE whatever the selection registers hold and whatever the pin does.
- R3: In manual mode (mode value 1), the primary manual register (address 1, bits 3:0) drives the primary path, as follows:
  - codes 0..7 give state LOCK (0) with the reference index equal to the code;
  - code 8 gives FREE (1);
  - code 9 gives PSEUDO (2);
  - code 10 gives HOLD (3).
  The new output appears on the clock edge after the write edge. In a fallback state the reference index keeps its last locked value.
- R4: In manual and pin modes, the secondary manual register (address 2, bits 3:0) drives the secondary path. It uses the same codes as R3, and code 11 gives state TRACK (4).
- R5: A write that carries an invalid value is discarded, and the register keeps its previous value. The invalid values are:
  - a primary code above 10;
  - a secondary code above 11;
  - mode value 3;
  - a pre-selection word in which either 4-bit half is above 10.
- R6: In pin mode (mode value 2), the primary path takes the low half of the pre-selection word (address 3, bits 3:0) when the filtered pin is 0. It takes the high half (bits 7:4) when the filtered pin is 1.
- R7: The pin never affects the secondary path, in any mode.
- R8: A pin level takes effect only after it has held for `DEB_LEN` consecutive cycles past the two-flop synchronizer. A pulse shorter than that leaves the selection unchanged.
- R9: Address 4, bit 0 reads the pin level after the two synchronizer flops.
- R10: Each change of a path's state or reference index raises that path's strobe for exactly one cycle. A write that leaves the output the same raises no strobe, and between changes the outputs hold steady.
- R11: Writes are accepted only while `wr_en` is high. Addresses 0 to 3 read back the mode, the primary code, the secondary code and the pre-selection word. Unused read bits are 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| sw_pin | input | 1 | Asynchronous external switch pin |
| pri_ref | output | 3 | Primary path reference index |
| pri_state | output | 3 | Primary path state code |
| pri_chg | output | 1 | Primary path change strobe |
| sec_ref | output | 3 | Secondary path reference index |
| sec_state | output | 3 | Secondary path state code |
| sec_chg | output | 1 | Secondary path change strobe |

## Verification

A wrong path state shows up at the state and reference ports one clock edge after the write that should have set it. Across every code the sweep predicts both the decoded state and the held index. A wrong debounce count shows up as a switchover that comes earlier or later than the predicted edge window, or as a short pulse that leaks through. A corrupted register shows up on read-back in the same cycle. A stray or missing strobe is caught in the single cycle after each write, and is also counted over the pin-driven intervals.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

    typedef enum logic [2:0] {
        PS_LOCK   = 3'd0,
        PS_FREE   = 3'd1,
        PS_PSEUDO = 3'd2,
        PS_HOLD   = 3'd3,
        PS_TRACK  = 3'd4
    } path_st_e;

    typedef enum logic [1:0] {
        MD_IDLE   = 2'd0,
        MD_MANUAL = 2'd1,
        MD_PIN    = 2'd2
    } ctl_mode_e;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_PRI  = 3'd1;
    localparam logic [2:0] A_SEC  = 3'd2;
    localparam logic [2:0] A_PRE  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

endpackage

// File: rtl/ref_sel_regs.sv
module ref_sel_regs
    import ref_sel_pkg::*;
#(
    parameter int NUM_REFS = 8,
    parameter int CODE_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pin_sync,
    output ctl_mode_e         mode_o,
    output logic [CODE_W-1:0] pri_sel_o,
    output logic [CODE_W-1:0] sec_sel_o,
    output logic [CODE_W-1:0] pre_lo_o,
    output logic [CODE_W-1:0] pre_hi_o
);
    localparam logic [CODE_W-1:0] C_FREE    = CODE_W'(NUM_REFS);
    localparam logic [CODE_W-1:0] C_PRI_MAX = CODE_W'(NUM_REFS + 2);
    localparam logic [CODE_W-1:0] C_SEC_MAX = CODE_W'(NUM_REFS + 3);

    logic [CODE_W-1:0] lo_half, hi_half;
    assign lo_half = wr_data[CODE_W-1:0];
    assign hi_half = wr_data[2*CODE_W-1:CODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o    <= MD_IDLE;
            pri_sel_o <= C_FREE;
            sec_sel_o <= C_FREE;
            pre_lo_o  <= '0;
            pre_hi_o  <= CODE_W'(1);
        end else if (wr_en) begin
            unique case (wr_addr)
                A_MODE: if (wr_data[1:0] != 2'd3) mode_o <= ctl_mode_e'(wr_data[1:0]);
                A_PRI:  if (lo_half <= C_PRI_MAX) pri_sel_o <= lo_half;
                A_SEC:  if (lo_half <= C_SEC_MAX) sec_sel_o <= lo_half;
                A_PRE:  if (lo_half <= C_PRI_MAX && hi_half <= C_PRI_MAX) begin
                            pre_lo_o <= lo_half;
                            pre_hi_o <= hi_half;
                        end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_MODE:  rd_data[1:0]        = mode_o;
            A_PRI:   rd_data[CODE_W-1:0] = pri_sel_o;
            A_SEC:   rd_data[CODE_W-1:0] = sec_sel_o;
            A_PRE:   rd_data             = {pre_hi_o, pre_lo_o};
            A_STAT:  rd_data[0]          = pin_sync;
            default: ;
        endcase
    end
endmodule

// File: rtl/ref_sel_pin_filter.sv
module ref_sel_pin_filter #(
    parameter int DEB_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o,
    output logic filt_o
);
    localparam int CNT_W = $clog2(DEB_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

    logic             meta_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_o <= 1'b0;
            filt_o <= 1'b0;
            cnt_q  <= '0;
        end else begin
            meta_q <= pin_i;
            sync_o <= meta_q;
            if (sync_o == filt_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                filt_o <= sync_o;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ref_sel_path_fsm.sv
module ref_sel_path_fsm
    import ref_sel_pkg::*;
#(
    parameter int NUM_REFS = 8,
    parameter int CODE_W   = 4,
    parameter int REF_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] req_code,
    output path_st_e          state_o,
    output logic [REF_W-1:0]  ref_o,
    output logic              chg_o
);
    localparam logic [CODE_W-1:0] C_FREE   = CODE_W'(NUM_REFS);
    localparam logic [CODE_W-1:0] C_PSEUDO = CODE_W'(NUM_REFS + 1);
    localparam logic [CODE_W-1:0] C_HOLD   = CODE_W'(NUM_REFS + 2);

    path_st_e         st_q, st_d, req_st;
    logic [REF_W-1:0] ref_q, ref_d;
    logic             chg_q;

    always_comb begin
        if (req_code < C_FREE)        req_st = PS_LOCK;
        else if (req_code == C_FREE)  req_st = PS_FREE;
        else if (req_code == C_PSEUDO) req_st = PS_PSEUDO;
        else if (req_code == C_HOLD)  req_st = PS_HOLD;
        else                          req_st = PS_TRACK;
    end

    always_comb begin
        st_d  = req_st;
        ref_d = ref_q;
        unique case (req_st)
            PS_LOCK:   ref_d = req_code[REF_W-1:0];
            PS_FREE,
            PS_PSEUDO,
            PS_HOLD,
            PS_TRACK:  ref_d = ref_q;
            default:   ref_d = ref_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_FREE;
            ref_q <= '0;
            chg_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ref_q <= ref_d;
            chg_q <= (st_d != st_q) || (ref_d != ref_q);
        end
    end

    // outputs
    always_comb begin
        state_o = st_q;
        ref_o   = ref_q;
        chg_o   = chg_q;
    end
endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
    import ref_sel_pkg::*;
#(
    parameter  int NUM_REFS = 8,
    parameter  int DEB_LEN  = 4,
    localparam int CODE_W   = $clog2(NUM_REFS + 4),
    localparam int REF_W    = $clog2(NUM_REFS),
    localparam int DATA_W   = 2 * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sw_pin,
    output logic [REF_W-1:0]  pri_ref,
    output logic [2:0]        pri_state,
    output logic              pri_chg,
    output logic [REF_W-1:0]  sec_ref,
    output logic [2:0]        sec_state,
    output logic              sec_chg
);
    localparam logic [CODE_W-1:0] C_FREE = CODE_W'(NUM_REFS);

    ctl_mode_e         mode;
    logic [CODE_W-1:0] pri_sel, sec_sel, pre_lo, pre_hi;
    logic [CODE_W-1:0] pri_req, sec_req;
    logic              pin_sync, pin_filt;
    path_st_e          pri_st, sec_st;

    ref_sel_regs #(.NUM_REFS(NUM_REFS), .CODE_W(CODE_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_sync(pin_sync), .mode_o(mode),
        .pri_sel_o(pri_sel), .sec_sel_o(sec_sel), .pre_lo_o(pre_lo), .pre_hi_o(pre_hi)
    );

    ref_sel_pin_filter #(.DEB_LEN(DEB_LEN)) pin_i (
        .clk(clk), .rst_n(rst_n), .pin_i(sw_pin), .sync_o(pin_sync), .filt_o(pin_filt)
    );

    always_comb begin
        unique case (mode)
            MD_MANUAL: begin pri_req = pri_sel;                     sec_req = sec_sel; end
            MD_PIN:    begin pri_req = pin_filt ? pre_hi : pre_lo;  sec_req = sec_sel; end
            default:   begin pri_req = C_FREE;                      sec_req = C_FREE;  end
        endcase
    end

    ref_sel_path_fsm #(.NUM_REFS(NUM_REFS), .CODE_W(CODE_W), .REF_W(REF_W)) pri_fsm_i (
        .clk(clk), .rst_n(rst_n), .req_code(pri_req),
        .state_o(pri_st), .ref_o(pri_ref), .chg_o(pri_chg)
    );

    ref_sel_path_fsm #(.NUM_REFS(NUM_REFS), .CODE_W(CODE_W), .REF_W(REF_W)) sec_fsm_i (
        .clk(clk), .rst_n(rst_n), .req_code(sec_req),
        .state_o(sec_st), .ref_o(sec_ref), .chg_o(sec_chg)
    );

    assign pri_state = pri_st;
    assign sec_state = sec_st;
endmodule

// File: rtl/ref_sel_ctrl_chk.sv
module ref_sel_ctrl_chk #(
    parameter int REF_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REF_W-1:0] pri_ref,
    input logic [2:0]       pri_state,
    input logic             pri_chg,
    input logic [REF_W-1:0] sec_ref,
    input logic [2:0]       sec_state,
    input logic             sec_chg
);
    // R10
    pri_strobe_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pri_chg |-> (pri_state != $past(pri_state) || pri_ref != $past(pri_ref)));

    // R10
    pri_steady_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_chg |-> ($stable(pri_state) && $stable(pri_ref)));

    // R10
    sec_strobe_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_chg |-> (sec_state != $past(sec_state) || sec_ref != $past(sec_ref)));

    // R10
    sec_steady_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_chg |-> ($stable(sec_state) && $stable(sec_ref)));

    // R7
    sec_moves_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_chg |-> $past(wr_en, 2));

    // R3
    pri_never_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pri_state <= 3'd3);

    // R4
    sec_state_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_state <= 3'd4);
endmodule

bind ref_sel_ctrl ref_sel_ctrl_chk #(.REF_W(REF_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .pri_ref(pri_ref), .pri_state(pri_state), .pri_chg(pri_chg),
    .sec_ref(sec_ref), .sec_state(sec_state), .sec_chg(sec_chg)
);

// File: tb/ref_sel_ctrl_tb.sv
`timescale 1ns/1ps
module ref_sel_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sw_pin = 1'b0;
    logic [2:0] pri_ref, pri_state, sec_ref, sec_state;
    logic       pri_chg, sec_chg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // expected model
    int m_mode = 0, m_pri = 8, m_sec = 8, m_lo = 0, m_hi = 1, m_pin = 0;
    int e_pst = 1, e_pref = 0, e_sst = 1, e_sref = 0;

    always #5 clk = ~clk;

    ref_sel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sw_pin(sw_pin),
        .pri_ref(pri_ref), .pri_state(pri_state), .pri_chg(pri_chg),
        .sec_ref(sec_ref), .sec_state(sec_state), .sec_chg(sec_chg)
    );

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int st_of(input int code);
        if (code < 8) return 0;
        return code - 7;
    endfunction

    // recompute expected outputs; returns change flags
    task automatic predict(output bit pc, output bit sc);
        int pcode, scode, nps, npr, nss, nsr;
        pcode = (m_mode == 0) ? 8 : (m_mode == 1) ? m_pri : (m_pin ? m_hi : m_lo);
        scode = (m_mode == 0) ? 8 : m_sec;
        nps = st_of(pcode); npr = (pcode < 8) ? pcode : e_pref;
        nss = st_of(scode); nsr = (scode < 8) ? scode : e_sref;
        pc = (nps != e_pst) || (npr != e_pref);
        sc = (nss != e_sst) || (nsr != e_sref);
        e_pst = nps; e_pref = npr; e_sst = nss; e_sref = nsr;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        rd_addr = a;
        #1;
        cmp(req, int'(rd_data), exp);
    endtask

    task automatic out_chk(input string req, input bit pc, input bit sc);
        cmp({req, " pri_state"}, int'(pri_state), e_pst);
        cmp({req, " pri_ref"},   int'(pri_ref),   e_pref);
        cmp({req, " sec_state"}, int'(sec_state), e_sst);
        cmp({req, " sec_ref"},   int'(sec_ref),   e_sref);
        cmp({req, " pri_chg"},   int'(pri_chg),   int'(pc));
        cmp({req, " sec_chg"},   int'(sec_chg),   int'(sc));
    endtask

    // write at one edge, outputs checked after the following edge
    task automatic wr(input string req, input logic [2:0] a, input logic [7:0] d);
        bit pc, sc;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: if (d[1:0] != 2'd3) m_mode = int'(d[1:0]);
            3'd1: if (d[3:0] <= 4'd10) m_pri = int'(d[3:0]);
            3'd2: if (d[3:0] <= 4'd11) m_sec = int'(d[3:0]);
            3'd3: if (d[3:0] <= 4'd10 && d[7:4] <= 4'd10) begin
                      m_lo = int'(d[3:0]); m_hi = int'(d[7:4]);
                  end
            default: ;
        endcase
        predict(pc, sc);
        @(negedge clk);
        out_chk(req, pc, sc);
    endtask

    // run n cycles, count strobes
    task automatic run_count(input int n, output int pcnt, output int scnt);
        pcnt = 0; scnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pcnt += int'(pri_chg);
            scnt += int'(sec_chg);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit pc, sc;
        int pcnt, scnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        out_chk("R1", 1'b0, 1'b0);
        rd_chk("R1 mode", 3'd0, 0);
        rd_chk("R1 pri", 3'd1, 8);
        rd_chk("R1 sec", 3'd2, 8);
        rd_chk("R1 pre", 3'd3, 8'h10);

        // R2 idle mode ignores selection registers
        wr("R2 idle pri", 3'd1, 8'd3);
        wr("R2 idle sec", 3'd2, 8'd6);
        rd_chk("R11 pri", 3'd1, 3);
        rd_chk("R11 sec", 3'd2, 6);

        // R11 no write without wr_en
        @(negedge clk);
        wr_addr = 3'd1; wr_data = 8'd9;
        @(negedge clk);
        rd_chk("R11 no wr_en", 3'd1, 3);

        wr("R3 enter manual", 3'd0, 8'd1);

        // R3 / R5 primary sweep over all 4-bit codes, twice
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 16; c++) begin
                wr((c > 10) ? "R5 pri reject" : "R3 pri code", 3'd1, 8'(c));
                rd_chk("R5 pri readback", 3'd1, m_pri);
            end

        // R4 / R5 secondary sweep
        for (int c = 15; c >= 0; c--) begin
            wr((c > 11) ? "R5 sec reject" : "R4 sec code", 3'd2, 8'(c));
            rd_chk("R5 sec readback", 3'd2, m_sec);
        end
        wr("R4 sec track", 3'd2, 8'd11);
        wr("R10 rewrite same", 3'd2, 8'd11);

        // R5 mode and pre-selection rejects
        wr("R5 mode 3", 3'd0, 8'd3);
        rd_chk("R5 mode readback", 3'd0, 1);
        wr("R5 pre hi bad", 3'd3, 8'hB5);
        rd_chk("R5 pre readback", 3'd3, 8'h10);
        wr("R5 pre lo bad", 3'd3, 8'h2C);
        rd_chk("R5 pre readback", 3'd3, 8'h10);

        // R7 pin ignored by primary in manual mode too
        wr("R3 pri 6", 3'd1, 8'd6);
        sw_pin = 1'b1;
        run_count(12, pcnt, scnt);
        cmp("R7 manual pin pri strobes", pcnt, 0);
        cmp("R7 manual pin sec strobes", scnt, 0);
        sw_pin = 1'b0;
        run_count(12, pcnt, scnt);

        // R6 pin mode
        wr("R6 pre", 3'd3, 8'h95);
        wr("R4 sec 2", 3'd2, 8'd2);
        wr("R6 pin mode lo", 3'd0, 8'd2);

        // R9 synchronizer depth, R8 debounce timing
        @(negedge clk);
        sw_pin = 1'b1;
        @(negedge clk);
        rd_chk("R9 status after 1 edge", 3'd4, 0);
        @(negedge clk);
        rd_chk("R9 status after 2 edges", 3'd4, 1);
        repeat (3) @(negedge clk);
        cmp("R8 not yet switched", int'(pri_state), 0);
        cmp("R8 not yet switched ref", int'(pri_ref), 5);
        pcnt = 0; scnt = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            pcnt += int'(pri_chg);
            scnt += int'(sec_chg);
        end
        m_pin = 1; predict(pc, sc);
        cmp("R8 one switch strobe", pcnt, 1);
        cmp("R7 sec no strobe", scnt, 0);
        out_chk("R6 pin hi", 1'b0, 1'b0);

        // R8 short low pulse ignored
        sw_pin = 1'b0;
        repeat (3) @(negedge clk);
        sw_pin = 1'b1;
        run_count(14, pcnt, scnt);
        cmp("R8 glitch no strobe", pcnt, 0);
        out_chk("R8 glitch", 1'b0, 1'b0);

        // R6 back to low entry
        sw_pin = 1'b0;
        run_count(14, pcnt, scnt);
        m_pin = 0; predict(pc, sc);
        cmp("R6 back low strobe", pcnt, 1);
        cmp("R7 sec no strobe", scnt, 0);
        out_chk("R6 pin lo", 1'b0, 1'b0);

        // R6 pre-selection rewrite takes effect with filtered pin low
        wr("R6 pre lo hold", 3'd3, 8'h0A);
        wr("R6 pre lo lock7", 3'd3, 8'h07);

        // R2 back to idle
        wr("R2 idle again", 3'd0, 8'd0);
        sw_pin = 1'b1;
        run_count(14, pcnt, scnt);
        cmp("R2 idle pin strobes", pcnt + scnt, 0);
        rd_chk("R9 status high", 3'd4, 1);
        out_chk("R2 idle hold", 1'b0, 1'b0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule